// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready Flags

This block moves 18-bit words from a write clock domain to a read clock domain. The two clocks run freely. They may be unrelated, or they may be the same clock. The write side has an active-low select, a direction select and a write enable, and it reports an input-ready flag. The read side has the same select and direction inputs and a read enable. It reports an output-ready flag and presents data from a register, with a separate output-enable signal that stands in for a tristate pad.

Storage is a 512-word array addressed through binary pointers. The pointers cross to the other domain in gray code. The read side places one word in its output register before anyone asks for it. When the FIFO has been empty, a newly written word appears on the output without any read request, and output-ready rising means a fresh word is waiting. When the last word has been consumed, the register keeps showing it. One reset input, active low, clears both domains.

Top module: `xdom_fifo`

## Requirements
- R1: A word is stored on a rising `wclk` edge exactly when `wcs_n`=0, `w_dir`=1, `w_en`=1 and `w_ready`=1. If any of these terms is missing, the word is dropped and never reaches the read side.
- R2: A word is consumed on a rising `rclk` edge exactly when `rcs_n`=0, `r_dir`=0, `r_en`=1 and `r_ready`=1. A request that lacks any of these terms leaves `r_ready` and `r_data` unchanged.
- R3: `r_data_oe` is 1 exactly when `rcs_n`=0 and `r_dir`=0. The enables and the flags have no effect on it.
- R4: While `rst_n` is 0, `w_ready` and `r_ready` are 0. Reset is held across at least four rising edges of each clock, and afterwards the FIFO is empty.
- R5: After `rst_n` is released, `w_ready` rises on the second rising `wclk` edge.
- R6: A word written into an empty FIFO is loaded into `r_data` on the third rising `rclk` edge after the write edge. A coincident edge does not count. `r_ready` rises on that same edge.
- R7: Words leave in the order they were accepted, for any mix of gating and any clock relation.
- R8: After the last word is consumed and `r_ready` falls, `r_data` keeps that word until `r_ready` rises again.
- R9: The FIFO holds 2^ADDR_W+1 words (513 by default): the array plus the output register. When it is full, `w_ready` is 0 and write attempts are dropped.
- R10: With identical clocks, a read from a full FIFO makes `w_ready` rise on the third rising `wclk` edge after the read edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Reset for both domains, active low |
| wclk | input | 1 | Write-side clock |
| wcs_n | input | 1 | Write-side select, active low |
| w_dir | input | 1 | Write-side direction, 1 = write |
| w_en | input | 1 | Write enable |
| w_data | input | DATA_W | Word to store |
| w_ready | output | 1 | Room available, synchronous to `wclk` |
| rclk | input | 1 | Read-side clock |
| rcs_n | input | 1 | Read-side select, active low |
| r_dir | input | 1 | Read-side direction, 0 = read |
| r_en | input | 1 | Read enable |
| r_data | output | DATA_W | Output register |
| r_data_oe | output | 1 | Drive enable for `r_data` |
| r_ready | output | 1 | Unread word in `r_data`, synchronous to `rclk` |

## Verification
The hardest state to reach is full with all 513 words in place. This needs the first word to have already fallen through into the output register, and the pointer synchronizers to have settled, before the last write. The bench fills the FIFO with the reader idle and keeps offering writes until `w_ready` stays low. It then frees exactly one slot and counts `wclk` edges until the flag recovers. Separate sweeps run unrelated clock periods with uneven gating densities. These drive the flags repeatedly into full and empty while pointer updates are still in flight.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int XF_DATA_W = 18;
  localparam int XF_ADDR_W = 9;

  // Direction select encoding shared by both ports
  typedef enum logic {
    XF_DIR_RD = 1'b0,
    XF_DIR_WR = 1'b1
  } xf_dir_e;
endpackage

// File: rtl/xf_sync.sv
module xf_sync #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  timeunit 1ns; timeprecision 100ps;

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xf_mem.sv
module xf_mem #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 9
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  timeunit 1ns; timeprecision 100ps;

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/xf_wside.sv
module xf_wside #(
  parameter int ADDR_W = 9
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W:0]   rptr_gray_s,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wptr_gray,
  output logic [ADDR_W:0]   wr_level,
  output logic              w_ready
);
  timeunit 1ns; timeprecision 100ps;

  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] CAP_LVL = PW'(1 << ADDR_W);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic          armed;
  logic [PW-1:0] wptr_bin, wptr_nxt, rptr_b, level_nxt;
  logic          full_nxt;

  assign wr_fire   = wr_req & w_ready;
  assign wptr_nxt  = wptr_bin + PW'(wr_fire);
  assign rptr_b    = g2b(rptr_gray_s);
  assign level_nxt = wptr_nxt - rptr_b;
  assign full_nxt  = (level_nxt == CAP_LVL);
  assign wr_level  = wptr_bin - rptr_b;
  assign waddr     = wptr_bin[ADDR_W-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      w_ready   <= 1'b0;
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else begin
      armed     <= 1'b1;
      w_ready   <= armed & ~full_nxt;
      wptr_bin  <= wptr_nxt;
      wptr_gray <= b2g(wptr_nxt);
    end
  end
endmodule

// File: rtl/xf_rside.sv
module xf_rside #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 9
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W:0]   wptr_gray_s,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_fire,
  output logic              out_load,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rptr_gray,
  output logic [DATA_W-1:0] r_data,
  output logic              r_ready
);
  timeunit 1ns; timeprecision 100ps;

  localparam int PW = ADDR_W + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic          armed;
  logic [PW-1:0] rptr_bin, rptr_nxt, wptr_b;
  logic          mem_empty;

  assign rd_fire   = rd_req & r_ready;
  assign wptr_b    = g2b(wptr_gray_s);
  assign mem_empty = (wptr_b == rptr_bin);
  // The output register refills when it is vacant or being consumed
  assign out_load  = armed & ~mem_empty & (~r_ready | rd_fire);
  assign rptr_nxt  = rptr_bin + PW'(out_load);
  assign raddr     = rptr_bin[ADDR_W-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      r_ready   <= 1'b0;
      r_data    <= '0;
      rptr_bin  <= '0;
      rptr_gray <= '0;
    end else begin
      armed     <= 1'b1;
      r_ready   <= out_load | (r_ready & ~rd_fire);
      if (out_load) r_data <= mem_rdata;
      rptr_bin  <= rptr_nxt;
      rptr_gray <= b2g(rptr_nxt);
    end
  end
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo
  import xf_pkg::*;
#(
  parameter int DATA_W = XF_DATA_W,
  parameter int ADDR_W = XF_ADDR_W
) (
  input  logic              rst_n,
  input  logic              wclk,
  input  logic              wcs_n,
  input  logic              w_dir,
  input  logic              w_en,
  input  logic [DATA_W-1:0] w_data,
  output logic              w_ready,
  input  logic              rclk,
  input  logic              rcs_n,
  input  logic              r_dir,
  input  logic              r_en,
  output logic [DATA_W-1:0] r_data,
  output logic              r_data_oe,
  output logic              r_ready
);
  timeunit 1ns; timeprecision 100ps;

  localparam int PW = ADDR_W + 1;

  logic              wr_req, rd_req, wr_fire, rd_fire, out_load;
  logic [PW-1:0]     wptr_gray, rptr_gray, wptr_gray_s, rptr_gray_s, wr_level;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] mem_rdata;

  assign wr_req    = ~wcs_n & (xf_dir_e'(w_dir) == XF_DIR_WR) & w_en;
  assign rd_req    = ~rcs_n & (xf_dir_e'(r_dir) == XF_DIR_RD) & r_en;
  assign r_data_oe = ~rcs_n & (xf_dir_e'(r_dir) == XF_DIR_RD);

  xf_wside #(.ADDR_W(ADDR_W)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .wr_req(wr_req), .rptr_gray_s(rptr_gray_s),
    .wr_fire(wr_fire), .waddr(waddr), .wptr_gray(wptr_gray),
    .wr_level(wr_level), .w_ready(w_ready)
  );

  xf_sync #(.W(PW)) u_sync_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rptr_gray), .q(rptr_gray_s)
  );

  xf_sync #(.W(PW)) u_sync_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wptr_gray), .q(wptr_gray_s)
  );

  xf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(w_data),
    .raddr(raddr), .rdata(mem_rdata)
  );

  xf_rside #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .rd_req(rd_req), .wptr_gray_s(wptr_gray_s),
    .mem_rdata(mem_rdata), .rd_fire(rd_fire), .out_load(out_load),
    .raddr(raddr), .rptr_gray(rptr_gray), .r_data(r_data), .r_ready(r_ready)
  );
endmodule

// File: rtl/xdom_fifo_chk.sv
module xdom_fifo_chk #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 9
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              w_ready,
  input logic              r_ready,
  input logic              wr_fire,
  input logic              rd_fire,
  input logic              out_load,
  input logic [ADDR_W:0]   wptr_gray,
  input logic [ADDR_W:0]   rptr_gray,
  input logic [ADDR_W:0]   wr_level,
  input logic [DATA_W-1:0] r_data
);
  timeunit 1ns; timeprecision 100ps;

  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] CAP_LVL = PW'(1 << ADDR_W);

  always @(negedge wclk) begin
    if (!rst_n) assert_reset_wready_low_R4: assert (!w_ready);
  end

  always @(negedge rclk) begin
    if (!rst_n) assert_reset_rready_low_R4: assert (!r_ready);
  end

  assert_wready_drop_on_write_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    $fell(w_ready) |-> $past(wr_fire));

  assert_level_bound_R9: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_level <= CAP_LVL);

  assert_rready_rise_on_load_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    $rose(r_ready) |-> $past(out_load));

  assert_rready_drop_on_read_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(r_ready) |-> $past(rd_fire));

  assert_hold_last_word_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    !out_load |=> $stable(r_data));

  assert_wgray_one_step_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  assert_rgray_one_step_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    $countones(rptr_gray ^ $past(rptr_gray)) <= 1);
endmodule

bind xdom_fifo xdom_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .w_ready(w_ready), .r_ready(r_ready),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .out_load(out_load),
  .wptr_gray(wptr_gray), .rptr_gray(rptr_gray), .wr_level(wr_level), .r_data(r_data)
);

// File: tb/test_xdom_fifo.sv
module test_xdom_fifo;
  timeunit 1ns; timeprecision 100ps;

  localparam int DW = 18;
  localparam int AW = 9;
  localparam int CAP = (1 << AW) + 1;

  logic wclk = 1'b0, rclk_free = 1'b0, tied = 1'b1, rclk;
  logic rst_n = 1'b0;
  logic wcs_n = 1'b1, w_dir = 1'b0, w_en = 1'b0;
  logic [DW-1:0] w_data = '0;
  logic rcs_n = 1'b1, r_dir = 1'b1, r_en = 1'b0;
  logic w_ready, r_ready, r_data_oe;
  logic [DW-1:0] r_data;

  int checks = 0, fails = 0, n_wr = 0, idx_rd = 0, guard = 0;
  logic [DW-1:0] held;
  logic [DW-1:0] q[$];

  always #5 wclk = ~wclk;
  always #7.3 rclk_free = ~rclk_free;
  assign rclk = tied ? wclk : rclk_free;

  xdom_fifo #(.DATA_W(DW), .ADDR_W(AW)) i_xdom_fifo (
    .rst_n(rst_n), .wclk(wclk), .wcs_n(wcs_n), .w_dir(w_dir), .w_en(w_en),
    .w_data(w_data), .w_ready(w_ready), .rclk(rclk), .rcs_n(rcs_n),
    .r_dir(r_dir), .r_en(r_en), .r_data(r_data), .r_data_oe(r_data_oe),
    .r_ready(r_ready)
  );

  function automatic logic [DW-1:0] word_of(input int i);
    return DW'(i * 97 + 11);
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wcs_n = 1'b1; w_dir = 1'b0; w_en = 1'b0;
    rcs_n = 1'b1; r_dir = 1'b1; r_en = 1'b0;
    fork
      repeat (4) @(posedge wclk);
      repeat (4) @(posedge rclk);
    join
    @(negedge wclk);
    chk(!w_ready, "R4 w_ready in reset", w_ready, 0);
    chk(!r_ready, "R4 r_ready in reset", r_ready, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_writer(input int base, input int n, input int thr);
    logic [31:0] st = 32'h1357_9BDF + 32'(base);
    int idx = 0;
    while (idx < n) begin
      @(negedge wclk);
      st = xs(st);
      wcs_n = 1'b0; w_dir = 1'b1; w_en = 1'b1;
      if (!(int'(st[3:0]) < thr)) begin
        case (st[5:4])
          2'd0:    wcs_n = 1'b1;
          2'd1:    w_dir = 1'b0;
          default: w_en  = 1'b0;
        endcase
      end
      w_data = word_of(base + idx);
      if (int'(st[3:0]) < thr && w_ready) begin
        q.push_back(word_of(base + idx));
        idx++;
      end
    end
    @(negedge wclk);
    w_en = 1'b0;
  endtask

  task automatic run_reader(input int base, input int n, input int thr);
    logic [31:0] st = 32'h2468_ACE1 + 32'(base);
    int got = 0;
    while (got < n) begin
      @(negedge rclk);
      st = xs(st);
      if (r_ready) begin
        if (q.size() == 0) chk(1'b0, "R7 word with empty model", r_data, 0);
        else chk(r_data == q[0], "R7 order", r_data, q[0]);
      end
      rcs_n = 1'b0; r_dir = 1'b0; r_en = 1'b1;
      if (!(int'(st[3:0]) < thr)) begin
        case (st[5:4])
          2'd0:    rcs_n = 1'b1;
          2'd1:    r_dir = 1'b1;
          default: r_en  = 1'b0;
        endcase
      end
      if (int'(st[3:0]) < thr && r_ready) begin
        void'(q.pop_front());
        got++;
      end
    end
    @(negedge rclk);
    r_en = 1'b0;
  endtask

  initial begin
    // ---------------- identical clocks ----------------
    do_reset();
    // R5: ready on the second write edge after release
    @(posedge wclk); #1;
    chk(!w_ready, "R5 first edge", w_ready, 0);
    @(posedge wclk); #1;
    chk(w_ready, "R5 second edge", w_ready, 1);

    // R3: output enable over every select/direction/enable combination
    for (int c = 0; c < 8; c++) begin
      rcs_n = c[0]; r_dir = c[1]; r_en = c[2];
      #1;
      chk(r_data_oe == (!c[0] && !c[1]), "R3 oe", r_data_oe, (!c[0] && !c[1]));
    end
    rcs_n = 1'b1; r_dir = 1'b1; r_en = 1'b0;

    // R6: first-word fall-through latency
    @(negedge wclk);
    wcs_n = 1'b0; w_dir = 1'b1; w_en = 1'b1; w_data = 18'h2A5A5;
    @(posedge wclk); #1;
    w_en = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(posedge rclk); #1;
      chk(r_ready == (k == 3), "R6 ready latency", r_ready, (k == 3));
    end
    chk(r_data == 18'h2A5A5, "R6 data with ready", r_data, 18'h2A5A5);

    // R2: read requests missing one term change nothing
    for (int c = 0; c < 3; c++) begin
      @(negedge rclk);
      rcs_n = (c == 0); r_dir = (c == 1); r_en = (c != 2);
      @(posedge rclk); #1;
      chk(r_ready && r_data == 18'h2A5A5, "R2 gated read", r_data, 18'h2A5A5);
    end
    @(negedge rclk);
    rcs_n = 1'b0; r_dir = 1'b0; r_en = 1'b1;
    @(posedge rclk); #1;
    chk(!r_ready, "R2 valid read consumes", r_ready, 0);
    // R8: held last word while valid reads keep being offered
    repeat (6) @(posedge rclk);
    #1;
    chk(!r_ready && r_data == 18'h2A5A5, "R8 held word", r_data, 18'h2A5A5);
    r_en = 1'b0;

    // R1: write attempts missing one term are dropped
    for (int c = 0; c < 3; c++) begin
      @(negedge wclk);
      wcs_n = (c == 0); w_dir = (c != 1); w_en = (c != 2);
      w_data = 18'h11111 + DW'(c);
    end
    @(negedge wclk);
    w_en = 1'b0; wcs_n = 1'b1;
    repeat (6) @(posedge rclk);
    #1;
    chk(!r_ready, "R1 gated writes dropped", r_ready, 0);
    chk(r_data == 18'h2A5A5, "R1 output untouched", r_data, 18'h2A5A5);

    // R9: fill with the reader idle
    n_wr = 0;
    for (int c = 0; c < 560; c++) begin
      @(negedge wclk);
      wcs_n = 1'b0; w_dir = 1'b1; w_en = 1'b1;
      w_data = word_of(n_wr);
      if (w_ready) n_wr++;
    end
    chk(n_wr == CAP, "R9 capacity", n_wr, CAP);
    chk(!w_ready, "R9 full flag", w_ready, 0);
    @(negedge wclk);
    w_en = 1'b0;
    chk(r_data == word_of(0), "R7 head word", r_data, word_of(0));

    // R10: one read from full, ready returns on third write edge
    @(negedge rclk);
    rcs_n = 1'b0; r_dir = 1'b0; r_en = 1'b1;
    @(posedge rclk); #1;
    r_en = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(posedge wclk); #1;
      chk(w_ready == (k == 3), "R10 ready recovery", w_ready, (k == 3));
    end

    // Drain and check order (R7)
    idx_rd = 1; guard = 0;
    while (idx_rd < CAP && guard < 3000) begin
      @(negedge rclk);
      guard++;
      if (r_ready) begin
        chk(r_data == word_of(idx_rd), "R7 drain order", r_data, word_of(idx_rd));
        idx_rd++;
        r_en = 1'b1;
      end else begin
        r_en = 1'b0;
      end
    end
    chk(idx_rd == CAP, "R7 drained count", idx_rd, CAP);
    @(negedge rclk);
    r_en = 1'b1;
    repeat (6) @(posedge rclk);
    #1;
    chk(!r_ready, "R9 no extra words after full", r_ready, 0);
    chk(r_data == word_of(CAP - 1), "R8 held last word", r_data, word_of(CAP - 1));
    r_en = 1'b0;

    // ---------------- unrelated clocks ----------------
    rst_n = 1'b0;
    #3;
    tied = 1'b0;
    do_reset();
    held = '0;
    for (int p = 0; p < 4; p++) begin
      int wthr = (p == 2) ? 3 : ((p == 3) ? 9 : 15);
      int rthr = (p == 1) ? 3 : ((p == 3) ? 9 : 15);
      int nw   = (p == 1) ? 700 : 300;
      fork
        run_writer(10000 * (p + 1), nw, wthr);
        run_reader(10000 * (p + 1), nw, rthr);
      join
      repeat (10) @(posedge rclk);
      #1;
      chk(!r_ready && q.size() == 0, "R7 sweep ends empty", q.size(), 0);
      chk(r_data == word_of(10000 * (p + 1) + nw - 1), "R8 sweep last word",
          r_data, word_of(10000 * (p + 1) + nw - 1));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule